// File: doc/BRIEF.md
# Timer Slave Trigger Controller

This block sits beside a timer counter and decides, every clock, whether the counter advances, whether it must be re-initialised together with a register update, and whether the counter enable must be set by hardware. It picks one trigger among two internal timer triggers, a both-edges pulse derived from channel 1, filtered channel 1, filtered channel 2 and an external trigger. It then interprets that trigger according to a 3-bit slave mode: re-initialise on edge, gate by level, start on edge, or use edges as the counting clock.

An optional synchronisation setting delays every trigger effect by exactly one clock. A master timer and a slave timer driven from the same event then start in step. Encoder mode codes are passed through and behave like the disabled mode here. The counter, the input filters and the enable register are outside the block.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: Slave modes 000, 001, 010 and 011 leave the counter under software control: `cnt_tick` and `cnt_en` follow `sw_en`, and `cnt_reinit` and `hw_start` stay low.
- R2: The trigger select code picks the trigger: 000 `itr0`, 010 `itr2`, 100 channel-1 both-edge pulse, 101 `ti1f`, 110 `ti2f`, 111 `etrf`. The reserved codes 001 and 011 give a trigger that is always low, so no trigger effect occurs.
- R3: The channel-1 both-edge source is high for one cycle in the cycle where `ti1f` differs from its value in the previous clock, and it is low otherwise.
- R4: In slave mode 100, `cnt_reinit` pulses high in each cycle in which the selected trigger is high and was low in the previous cycle. `cnt_tick` follows `sw_en`.
- R5: In slave mode 101, `cnt_tick` equals the selected trigger level, and `cnt_en` is `sw_en` OR that level.
- R6: In slave mode 110, `hw_start` pulses high on each rising edge of the selected trigger, and `cnt_tick` follows `sw_en`.
- R7: In slave mode 111, `cnt_tick` is high for one cycle on each rising edge of the selected trigger while `sw_en` is high, and it is low otherwise.
- R8: With `sync_dly` high, the trigger level and rising edge used by R4 to R7 are those of the previous clock cycle.
- R9: While `rst` is high, all four outputs are low and the trigger history is cleared. A trigger that is already high in the first cycle after reset therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Software counter enable |
| slave_mode | input | 3 | Slave mode code |
| trig_sel | input | 3 | Trigger source select |
| sync_dly | input | 1 | Delay trigger effects by one cycle |
| itr0 | input | 1 | Internal trigger 0 |
| itr2 | input | 1 | Internal trigger 2 |
| ti1f | input | 1 | Filtered channel 1 |
| ti2f | input | 1 | Filtered channel 2 |
| etrf | input | 1 | Filtered external trigger |
| cnt_tick | output | 1 | Counter advance enable for this cycle |
| cnt_en | output | 1 | Effective counter enable |
| cnt_reinit | output | 1 | Re-initialise counter and update registers |
| hw_start | output | 1 | Hardware set of the counter enable |

## Verification
The assertions check on every cycle that re-initialise and start requests appear only in their own modes. They check that reserved selects never cause a re-initialise, that the delayed trigger level equals the previous input, and that edge-clocked ticks never come on two consecutive cycles. Whether each output matches the chosen source and mode in the right cycle can only be shown by the bench's scenarios. The same holds for the channel-1 pulse source, the one-cycle delay and the edge seen right after reset. The bench compares all four outputs with its reference model every clock, over every mode, select and delay combination and across resets.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        SM_OFF    = 3'd0,
        SM_ENC_A  = 3'd1,
        SM_ENC_B  = 3'd2,
        SM_ENC_C  = 3'd3,
        SM_RESET  = 3'd4,
        SM_GATED  = 3'd5,
        SM_START  = 3'd6,
        SM_EXTCLK = 3'd7
    } slave_mode_e;

    typedef enum logic [SEL_W-1:0] {
        TS_ITR0  = 3'd0,
        TS_RSV_A = 3'd1,
        TS_ITR2  = 3'd2,
        TS_RSV_B = 3'd3,
        TS_CH1ED = 3'd4,
        TS_CH1F  = 3'd5,
        TS_CH2F  = 3'd6,
        TS_EXT   = 3'd7
    } trig_sel_e;

    typedef struct packed {
        logic level;
        logic rise;
    } trig_evt_t;

    typedef struct packed {
        logic tick;
        logic en;
        logic reinit;
        logic start;
    } cnt_ctl_t;

    function automatic logic is_reserved(input trig_sel_e s);
        return (s == TS_RSV_A) || (s == TS_RSV_B);
    endfunction
endpackage

// File: rtl/tsc_src_mux.sv
module tsc_src_mux
    import tsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_sel_e sel,
    input  logic      itr0,
    input  logic      itr2,
    input  logic      ti1f,
    input  logic      ti2f,
    input  logic      etrf,
    output logic      trig_raw
);
    logic ti1_q;
    logic ti1_both;

    always_ff @(posedge clk) begin
        if (rst) ti1_q <= 1'b0;
        else     ti1_q <= ti1f;
    end

    assign ti1_both = ti1f ^ ti1_q;

    always_comb begin
        unique case (sel)
            TS_ITR0:  trig_raw = itr0;
            TS_ITR2:  trig_raw = itr2;
            TS_CH1ED: trig_raw = ti1_both;
            TS_CH1F:  trig_raw = ti1f;
            TS_CH2F:  trig_raw = ti2f;
            TS_EXT:   trig_raw = etrf;
            default:  trig_raw = 1'b0;
        endcase
    end

    // R3: a steady channel-1 input never yields an edge pulse
    a_r3_ed_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel == TS_CH1ED && $stable(ti1f) && !$past(rst)) |-> !trig_raw);
endmodule

// File: rtl/tsc_evt_stage.sv
module tsc_evt_stage
    import tsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_raw,
    input  logic      sync_dly,
    output trig_evt_t evt
);
    logic trig_q;
    logic rise_now;
    logic rise_d;
    logic lvl_d;

    assign rise_now = trig_raw & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            rise_d <= 1'b0;
            lvl_d  <= 1'b0;
        end else begin
            trig_q <= trig_raw;
            rise_d <= rise_now;
            lvl_d  <= trig_raw;
        end
    end

    always_comb begin
        if (sync_dly) begin
            evt.level = lvl_d;
            evt.rise  = rise_d;
        end else begin
            evt.level = trig_raw;
            evt.rise  = rise_now;
        end
    end

    // R8: delayed level is last cycle's trigger
    a_r8_delay_level: assert property (@(posedge clk) disable iff (rst)
        (sync_dly && !$past(rst)) |-> (evt.level == $past(trig_raw)));
endmodule

// File: rtl/tsc_mode_dec.sv
module tsc_mode_dec
    import tsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slave_mode_e mode,
    input  logic        sw_en,
    input  logic        sync_dly,
    input  trig_sel_e   sel,
    input  trig_evt_t   evt,
    output cnt_ctl_t    ctl
);
    always_comb begin
        ctl = '0;
        if (!rst) begin
            ctl.tick = sw_en;
            ctl.en   = sw_en;
            unique case (mode)
                SM_RESET:  ctl.reinit = evt.rise;
                SM_GATED: begin
                    ctl.tick = evt.level;
                    ctl.en   = sw_en | evt.level;
                end
                SM_START:  ctl.start = evt.rise;
                SM_EXTCLK: ctl.tick  = evt.rise & sw_en;
                default:   ;
            endcase
        end
    end

    // R4: re-initialise only in reset mode
    a_r4_reinit_mode: assert property (@(posedge clk) disable iff (rst)
        ctl.reinit |-> (mode == SM_RESET));
    // R6: hardware start only in trigger-start mode
    a_r6_start_mode: assert property (@(posedge clk) disable iff (rst)
        ctl.start |-> (mode == SM_START));
    // R7: edge-clocked ticks are never back to back under a fixed setup
    a_r7_tick_sparse: assert property (@(posedge clk) disable iff (rst)
        (mode == SM_EXTCLK && ctl.tick) |=>
        !(ctl.tick && $stable(mode) && $stable(sel) && $stable(sync_dly)));
    // R1: software-controlled modes never request trigger actions
    a_r1_sw_modes: assert property (@(posedge clk) disable iff (rst)
        (mode inside {SM_OFF, SM_ENC_A, SM_ENC_B, SM_ENC_C}) |-> !(ctl.reinit || ctl.start));
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_en,
    input  logic [MODE_W-1:0] slave_mode,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              sync_dly,
    input  logic              itr0,
    input  logic              itr2,
    input  logic              ti1f,
    input  logic              ti2f,
    input  logic              etrf,
    output logic              cnt_tick,
    output logic              cnt_en,
    output logic              cnt_reinit,
    output logic              hw_start
);
    trig_sel_e   sel;
    slave_mode_e mode;
    logic        trig_raw;
    trig_evt_t   evt;
    cnt_ctl_t    ctl;

    assign sel  = trig_sel_e'(trig_sel);
    assign mode = slave_mode_e'(slave_mode);

    tsc_src_mux u_mux (
        .clk(clk), .rst(rst), .sel(sel),
        .itr0(itr0), .itr2(itr2), .ti1f(ti1f), .ti2f(ti2f), .etrf(etrf),
        .trig_raw(trig_raw)
    );

    tsc_evt_stage u_evt (
        .clk(clk), .rst(rst), .trig_raw(trig_raw), .sync_dly(sync_dly), .evt(evt)
    );

    tsc_mode_dec u_dec (
        .clk(clk), .rst(rst), .mode(mode), .sw_en(sw_en),
        .sync_dly(sync_dly), .sel(sel), .evt(evt), .ctl(ctl)
    );

    assign cnt_tick   = ctl.tick;
    assign cnt_en     = ctl.en;
    assign cnt_reinit = ctl.reinit;
    assign hw_start   = ctl.start;

    // R2: a reserved select never re-initialises the counter
    a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (is_reserved(sel) && !sync_dly) |-> !cnt_reinit);
    // R9: outputs are low during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |-> !(cnt_tick || cnt_en || cnt_reinit || hw_start));
endmodule

// File: tb/tmr_slave_ctrl_tb.sv
module tmr_slave_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_en = 1'b0;
    logic [2:0] slave_mode = 3'd0;
    logic [2:0] trig_sel = 3'd0;
    logic       sync_dly = 1'b0;
    logic       itr0 = 1'b0, itr2 = 1'b0, ti1f = 1'b0, ti2f = 1'b0, etrf = 1'b0;
    logic       cnt_tick, cnt_en, cnt_reinit, hw_start;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference history
    bit m_trq = 0, m_ti1q = 0, m_rsd = 0, m_lvd = 0;

    always #5 clk = ~clk;

    tmr_slave_ctrl u_dut (
        .clk(clk), .rst(rst), .sw_en(sw_en), .slave_mode(slave_mode),
        .trig_sel(trig_sel), .sync_dly(sync_dly), .itr0(itr0), .itr2(itr2),
        .ti1f(ti1f), .ti2f(ti2f), .etrf(etrf), .cnt_tick(cnt_tick),
        .cnt_en(cnt_en), .cnt_reinit(cnt_reinit), .hw_start(hw_start)
    );

    function automatic bit ref_raw();
        case (trig_sel)
            3'd0: return itr0;
            3'd2: return itr2;
            3'd4: return ti1f ^ m_ti1q;
            3'd5: return ti1f;
            3'd6: return ti2f;
            3'd7: return etrf;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_tag();
        string t;
        case (slave_mode)
            3'd4: t = "R4";
            3'd5: t = "R5";
            3'd6: t = "R6";
            3'd7: t = "R7";
            default: t = "R1";
        endcase
        if (trig_sel == 3'd1 || trig_sel == 3'd3) t = {t, " R2"};
        else if (trig_sel == 3'd4) t = {t, " R3"};
        if (sync_dly) t = {t, " R8"};
        if (rst) t = {t, " R9"};
        return t;
    endfunction

    task automatic compare();
        bit raw, rnow, lvl, rs;
        bit [3:0] exp_v, act_v;
        raw  = ref_raw();
        rnow = raw && !m_trq;
        lvl  = sync_dly ? m_lvd : raw;
        rs   = sync_dly ? m_rsd : rnow;
        exp_v = '0;
        if (!rst) begin
            exp_v[3] = sw_en;
            exp_v[2] = sw_en;
            case (slave_mode)
                3'd4: exp_v[1] = rs;
                3'd5: begin exp_v[3] = lvl; exp_v[2] = sw_en || lvl; end
                3'd6: exp_v[0] = rs;
                3'd7: exp_v[3] = rs && sw_en;
                default: ;
            endcase
        end
        act_v = {cnt_tick, cnt_en, cnt_reinit, hw_start};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: mode=%0d sel=%0d dly=%0d {tick,en,reinit,start} actual=%b expected=%b",
                     req_tag(), slave_mode, trig_sel, sync_dly, act_v, exp_v);
        end
    endtask

    task automatic advance();
        bit raw;
        raw = ref_raw();
        @(posedge clk);
        #1;
        if (rst) begin
            m_trq = 0; m_ti1q = 0; m_rsd = 0; m_lvd = 0;
        end else begin
            m_rsd  = raw && !m_trq;
            m_lvd  = raw;
            m_trq  = raw;
            m_ti1q = ti1f;
        end
    endtask

    task automatic step(input int slow);
        @(negedge clk);
        if ($urandom_range(0, slow) == 0) itr0 = ~itr0;
        if ($urandom_range(0, slow) == 0) itr2 = ~itr2;
        if ($urandom_range(0, slow) == 0) ti1f = ~ti1f;
        if ($urandom_range(0, slow) == 0) ti2f = ~ti2f;
        if ($urandom_range(0, slow) == 0) etrf = ~etrf;
        if ($urandom_range(0, 7) == 0) sw_en = ~sw_en;
        #3;
        compare();
        advance();
    endtask

    initial begin
        // R9: reset with a trigger already high
        rst = 1'b1; slave_mode = 3'd4; trig_sel = 3'd7; etrf = 1'b1; sw_en = 1'b1;
        repeat (3) begin @(negedge clk); #3; compare(); advance(); end
        rst = 1'b0;
        // first cycle after reset: high trigger counts as rising edge (R9, R4)
        @(negedge clk); #3; compare(); advance();
        for (int c = 0; c < 128; c++) begin
            slave_mode = c[2:0];
            trig_sel   = c[5:3];
            sync_dly   = c[6];
            if (c % 32 == 31) rst = 1'b1;
            for (int k = 0; k < 24; k++) begin
                if (k == 2) rst = 1'b0;
                step((k < 12) ? 1 : 3);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule